// File: doc/BRIEF.md
# Balanced Right-to-Left Scalar Multiplication Controller

This block computes Q = k·P by walking the scalar k from its least significant bit upward. It keeps two live values, the accumulator Q (which starts at the group identity) and the running multiple S (which starts at P). Each iteration launches two group operations in the same cycle on two identical operation units: the accumulate step Q+S and the doubling step S+S. The doubling always replaces S. The accumulate result goes to the Q slot when the current key bit is 1. When the bit is 0, it goes to a dummy slot that nothing reads. The order, timing and kind of operations are therefore the same for every scalar.

In this build the group is the integers modulo a parameter MOD under addition, so the expected result is k·P mod MOD. The operation units are pipelined modular adders with a parameterised latency. A caller drives a scalar and a point below MOD together with a one-cycle start. It waits for the done pulse and then reads the result. The result stays on its port until the next accepted start.

Top module: `balanced_scalar_mult`

## Requirements
- R1: After reset, busy_o and done_o are 0 and result_o is 0.
- R2: A start_i seen while idle latches scalar_i and point_i. busy_o is 1 on the next cycle, and the run starts from Q = 0 and S = point_i.
- R3: When done_o is 1, result_o equals (scalar × point) mod MOD. Bit 0 of the scalar is processed first and bit KW-1 last.
- R4: done_o is high for exactly one cycle. It rises exactly KW·(LAT+1) clock edges after the edge that accepted start_i, whatever the scalar value, including 0 and all ones.
- R5: Both operation units are issued in the same cycle of every iteration, and their results return in the same cycle.
- R6: In an iteration whose key bit is 0, the accumulate result is written only to the dummy slot, and Q keeps its value.
- R7: A start_i seen while busy_o is 1 is ignored. The running computation and its latency are unaffected.
- R8: While the block is idle and no start is given, result_o holds its value even if scalar_i and point_i change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to begin a multiplication |
| scalar_i | input | KW | Scalar k, sampled on an accepted start |
| point_i | input | W | Group element P (must be below MOD), sampled on an accepted start |
| busy_o | output | 1 | A multiplication is in progress |
| done_o | output | 1 | One-cycle pulse: result_o holds k·P mod MOD |
| result_o | output | W | Current Q value |

## Verification
The bench measures the latency from the accepted start to done for k = 0, k with all bits set, single-bit scalars and several random scalars. A controller that skipped the dummy addition or branched on the key bit would give a latency that depends on the scalar. A controller that wrote the dummy result into Q would give wrong products for scalars with zero bits, for example a nonzero result for k = 0. The bench also issues a second start in the middle of a run and checks that neither the result nor the latency moves. Finally it changes the inputs while the block is idle and checks that the output holds, which catches a block that samples its inputs outside an accepted start.

// File: rtl/bsm_pkg.sv
package bsm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } state_e;

  localparam int unsigned NUM_SLOTS  = 3;
  localparam int unsigned SLOT_Q     = 0;
  localparam int unsigned SLOT_S     = 1;
  localparam int unsigned SLOT_DUMMY = 2;
endpackage

// File: rtl/bsm_op_unit.sv
module bsm_op_unit #(
  parameter int unsigned W   = 16,
  parameter int unsigned MOD = 65521,
  parameter int unsigned LAT = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         vld_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         vld_o,
  output logic [W-1:0] res_o
);
  localparam logic [W:0] MOD_W = (W+1)'(MOD);

  logic [W:0]   sum;
  logic [W:0]   sub;
  logic [W-1:0] red;

  always_comb begin
    sum = {1'b0, a_i} + {1'b0, b_i};
    sub = sum - MOD_W;
    red = (sum >= MOD_W) ? sub[W-1:0] : sum[W-1:0];
  end

  logic [LAT-1:0] vld_q;
  logic [W-1:0]   dat_q [LAT];

  for (genvar g = 0; g < LAT; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          vld_q[0] <= 1'b0;
          dat_q[0] <= '0;
        end else begin
          vld_q[0] <= vld_i;
          if (vld_i) dat_q[0] <= red;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          vld_q[g] <= 1'b0;
          dat_q[g] <= '0;
        end else begin
          vld_q[g] <= vld_q[g-1];
          dat_q[g] <= dat_q[g-1];
        end
      end
    end
  end

  assign vld_o = vld_q[LAT-1];
  assign res_o = dat_q[LAT-1];
endmodule

// File: rtl/bsm_slot_bank.sv
module bsm_slot_bank #(
  parameter int unsigned W     = 16,
  parameter int unsigned SLOTS = 3,
  localparam int unsigned SAW  = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_a_i,
  input  logic [SAW-1:0]        addr_a_i,
  input  logic [W-1:0]          data_a_i,
  input  logic                  we_b_i,
  input  logic [SAW-1:0]        addr_b_i,
  input  logic [W-1:0]          data_b_i,
  output logic [SLOTS-1:0][W-1:0] slots_o
);
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        slots_o[s] <= '0;
      end else if (we_a_i && addr_a_i == SAW'(s)) begin
        slots_o[s] <= data_a_i;
      end else if (we_b_i && addr_b_i == SAW'(s)) begin
        slots_o[s] <= data_b_i;
      end
    end
  end
endmodule

// File: rtl/bsm_seq.sv
module bsm_seq
  import bsm_pkg::*;
#(
  parameter int unsigned KW = 8,
  localparam int unsigned IW = (KW > 1) ? $clog2(KW) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [KW-1:0] scalar_i,
  input  logic          res_vld_i,
  output logic          init_o,
  output logic          issue_o,
  output logic          wb_o,
  output logic          key_bit_o,
  output logic          busy_o,
  output logic          done_o
);
  state_e        state_q;
  logic [KW-1:0] k_q;
  logic [IW-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      k_q     <= '0;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          k_q     <= scalar_i;
          idx_q   <= '0;
          state_q <= ST_ISSUE;
        end
        ST_ISSUE: state_q <= ST_WAIT;
        ST_WAIT: if (res_vld_i) begin
          if (idx_q == IW'(KW-1)) begin
            state_q <= ST_DONE;
          end else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= ST_ISSUE;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // key bit only steers the write slot, never the schedule
  assign key_bit_o = k_q[idx_q];
  assign init_o    = (state_q == ST_IDLE) && start_i;
  assign issue_o   = (state_q == ST_ISSUE);
  assign wb_o      = (state_q == ST_WAIT) && res_vld_i;
  assign busy_o    = (state_q == ST_ISSUE) || (state_q == ST_WAIT);
  assign done_o    = (state_q == ST_DONE);
endmodule

// File: rtl/balanced_scalar_mult.sv
module balanced_scalar_mult
  import bsm_pkg::*;
#(
  parameter int unsigned W   = 16,
  parameter int unsigned KW  = 8,
  parameter int unsigned LAT = 2,
  parameter int unsigned MOD = 65521
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [KW-1:0] scalar_i,
  input  logic [W-1:0]  point_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [W-1:0]  result_o
);
  localparam int unsigned SAW = $clog2(NUM_SLOTS);

  logic init, issue, wb, key_bit;
  logic add_vld, dbl_vld;
  logic [W-1:0] add_res, dbl_res;
  logic [NUM_SLOTS-1:0][W-1:0] slots;
  logic [W-1:0] q_val, s_val;

  logic           we_a, we_b;
  logic [SAW-1:0] addr_a, addr_b;
  logic [W-1:0]   data_a, data_b;

  assign q_val = slots[SLOT_Q];
  assign s_val = slots[SLOT_S];

  bsm_seq #(.KW(KW)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .scalar_i  (scalar_i),
    .res_vld_i (add_vld),
    .init_o    (init),
    .issue_o   (issue),
    .wb_o      (wb),
    .key_bit_o (key_bit),
    .busy_o    (busy_o),
    .done_o    (done_o)
  );

  bsm_op_unit #(.W(W), .MOD(MOD), .LAT(LAT)) u_add (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vld_i  (issue),
    .a_i    (q_val),
    .b_i    (s_val),
    .vld_o  (add_vld),
    .res_o  (add_res)
  );

  bsm_op_unit #(.W(W), .MOD(MOD), .LAT(LAT)) u_dbl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vld_i  (issue),
    .a_i    (s_val),
    .b_i    (s_val),
    .vld_o  (dbl_vld),
    .res_o  (dbl_res)
  );

  always_comb begin
    we_a   = 1'b0;
    addr_a = SAW'(SLOT_Q);
    data_a = '0;
    we_b   = 1'b0;
    addr_b = SAW'(SLOT_S);
    data_b = '0;
    if (init) begin
      we_a   = 1'b1;
      we_b   = 1'b1;
      data_b = point_i;
    end else if (wb) begin
      we_a   = 1'b1;
      addr_a = key_bit ? SAW'(SLOT_Q) : SAW'(SLOT_DUMMY);
      data_a = add_res;
      we_b   = 1'b1;
      data_b = dbl_res;
    end
  end

  bsm_slot_bank #(.W(W), .SLOTS(NUM_SLOTS)) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_a_i   (we_a),
    .addr_a_i (addr_a),
    .data_a_i (data_a),
    .we_b_i   (we_b),
    .addr_b_i (addr_b),
    .data_b_i (data_b),
    .slots_o  (slots)
  );

  assign result_o = q_val;
endmodule

// File: rtl/bsm_checker.sv
module bsm_checker #(
  parameter int unsigned W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic         busy_o,
  input logic         done_o,
  input logic [W-1:0] result_o,
  input logic         add_vld,
  input logic         dbl_vld,
  input logic         wb,
  input logic         key_bit,
  input logic [W-1:0] q_val
);
  a_r5_units_lockstep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    add_vld == dbl_vld);

  a_r6_dummy_keeps_q: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb && !key_bit) |=> $stable(q_val));

  a_r4_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r2_busy_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  a_r8_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !done_o && !start_i) |=> $stable(result_o));
endmodule

bind balanced_scalar_mult bsm_checker #(.W(W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .result_o (result_o),
  .add_vld  (add_vld),
  .dbl_vld  (dbl_vld),
  .wb       (wb),
  .key_bit  (key_bit),
  .q_val    (q_val)
);

// File: tb/balanced_scalar_mult_tb.sv
`timescale 1ns/1ps
module balanced_scalar_mult_tb;
  localparam int unsigned W   = 16;
  localparam int unsigned KW  = 8;
  localparam int unsigned LAT = 2;
  localparam int unsigned MOD = 65521;
  localparam int unsigned RUN_CYC = KW * (LAT + 1);

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [KW-1:0] scalar_i = '0;
  logic [W-1:0]  point_i = '0;
  logic          busy_o, done_o;
  logic [W-1:0]  result_o;

  int n_checks = 0;
  int n_fails  = 0;
  int cyc      = 0;

  balanced_scalar_mult #(.W(W), .KW(KW), .LAT(LAT), .MOD(MOD)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .scalar_i(scalar_i), .point_i(point_i),
    .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
  );

  always #10 clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      chk(1'b0, "watchdog", cyc, 150000);
      finish_up();
    end
  end

  function automatic longint expect_q(input longint k, input longint p);
    return (k * p) % MOD;
  endfunction

  // launch a run; optionally pulse a second start mid-run (R7)
  task automatic run_case(input logic [KW-1:0] k, input logic [W-1:0] p,
                          input bit poke, input logic [KW-1:0] k2, input string tag);
    int n;
    @(negedge clk_i);
    start_i = 1'b1; scalar_i = k; point_i = p;
    @(posedge clk_i); #1;
    start_i = 1'b0;
    chk(busy_o == 1'b1, {"R2 busy after start ", tag}, busy_o, 1);
    n = 0;
    while (!done_o && n < 4 * RUN_CYC) begin
      if (poke && n == 4) begin
        @(negedge clk_i);
        start_i = 1'b1; scalar_i = k2; point_i = p ^ 16'h00ff;
        @(posedge clk_i); #1;
        start_i = 1'b0;
      end else begin
        @(posedge clk_i); #1;
      end
      n++;
    end
    chk(n == RUN_CYC, {"R4 latency ", tag}, n, RUN_CYC);
    chk(result_o == W'(expect_q(k, p)), {"R3 result ", tag}, result_o, expect_q(k, p));
    @(posedge clk_i); #1;
    chk(done_o == 1'b0, {"R4 done single cycle ", tag}, done_o, 0);
    chk(busy_o == 1'b0, {"R4 idle after done ", tag}, busy_o, 0);
  endtask

  task automatic t_reset();
    #1;
    chk(busy_o == 1'b0, "R1 busy at reset", busy_o, 0);
    chk(done_o == 1'b0, "R1 done at reset", done_o, 0);
    chk(result_o == '0, "R1 result at reset", result_o, 0);
  endtask

  task automatic t_corners();
    run_case(8'h00, 16'd1234, 1'b0, '0, "R6 k=0");
    run_case(8'hff, 16'd65520, 1'b0, '0, "k all ones");
    run_case(8'h01, 16'd777, 1'b0, '0, "k=1 lsb");
    run_case(8'h80, 16'd40000, 1'b0, '0, "R6 k msb only");
    run_case(8'h55, 16'd65000, 1'b0, '0, "R6 alternating");
  endtask

  task automatic t_random();
    for (int i = 0; i < 8; i++) begin
      logic [KW-1:0] k;
      logic [W-1:0]  p;
      k = KW'($urandom);
      p = W'($urandom % MOD);
      run_case(k, p, 1'b0, '0, "random");
    end
  endtask

  task automatic t_start_busy();
    run_case(8'h3c, 16'd5555, 1'b1, 8'hff, "R7 start while busy");
  endtask

  task automatic t_idle_hold();
    logic [W-1:0] held;
    held = result_o;
    @(negedge clk_i);
    scalar_i = 8'ha7; point_i = 16'd999;
    repeat (6) @(posedge clk_i);
    #1;
    chk(result_o == held, "R8 result holds while idle", result_o, held);
    chk(busy_o == 1'b0, "R8 no run without start", busy_o, 0);
  endtask

  initial begin
    t_reset();
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    t_corners();
    t_idle_hold();
    t_random();
    t_start_busy();
    t_idle_hold();
    finish_up();
  end
endmodule